// File: doc/BRIEF.md
# Link-side Transmit Sequencer for a Nibble-wide PHY Interface

This block is the transmit controller on the link side of a PHY-link interface. The interface uses a 2-bit control bus and a 4-bit data bus. When a packet is pending, the block raises a request and waits for the PHY to grant the bus. It then takes the bus. If its first nibble is not yet available, it parks the bus with a hold code. Once data is available it streams the packet one nibble per clock under the transmit code. After the final nibble it closes with a single idle cycle and lets go of the lines.

A packet can be marked for chaining. In that case the sequencer drives hold rather than idle after the final nibble and keeps ownership. It waits for the PHY's next grant pattern and sends the following packet without a new request. Every packet in one ownership must use the speed code that the first packet set. A later packet with a different code is still sent, but the block flags it.

The packet source presents a nibble, a valid flag, a last flag, a chain flag and a speed code. It sees the nibble consumed in every cycle in which the ready output is high. The link's control and data outputs are registered. A separate enable output tells the pad logic when these lines are actually driven.

Top module: `lnk_tx_seq`

## Requirements
- R1: From idle, the cycle after `send_req` is seen high, `link_req` is high. It stays high, with `link_oe` low, until a grant is recognised.
- R2: A grant is recognised when `phy_ctl` was 2'b11 on the previous clock and is 2'b00 on the current clock. The PHY may hold 2'b11 for any number of clocks. In the cycle after a grant, `link_req` is low and `link_oe` is high. A grant pattern while no request is pending has no effect on any output.
- R3: After a grant, while `pkt_valid` is low before a packet's first nibble, the link drives hold (`link_ctl` = 2'b01) with `link_d` = 4'b0000.
- R4: In each cycle that `pkt_valid` is high while the link may send, `pkt_ready` is high. In the next cycle, `link_ctl` = 2'b10 (transmit) and `link_d` carries that nibble. `pkt_ready` is never high while `pkt_valid` is low.
- R5: After the nibble taken with `pkt_last` high and `pkt_chain` low, the link drives idle (2'b00, data 0000) with `link_oe` high for exactly one cycle. `link_oe` is low in the cycle after that.
- R6: After the nibble taken with `pkt_last` and `pkt_chain` both high, the link drives hold instead of idle. It holds the bus until the next grant pattern, with `link_req` staying low, and then sends the next packet under transmit.
- R7: The speed code of the first packet of an ownership is kept. `speed_err` pulses high for one cycle when a chained packet's first nibble goes out with a different speed code. This pulse appears in the same cycle as that nibble on `link_d`. The packet is still sent.
- R8: `link_oe` is high only from the first hold or transmit cycle through the closing idle cycle. Whenever `link_oe` is low, `link_ctl` and `link_d` are zero. After reset, all outputs are zero.
- R9: If `pkt_valid` drops in the middle of a packet, the link keeps driving transmit with `link_d` = 4'b0000 and consumes nothing until `pkt_valid` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_req | input | 1 | A packet is pending; start a bus request |
| pkt_data | input | 4 | Packet nibble from the source |
| pkt_valid | input | 1 | `pkt_data` is available |
| pkt_last | input | 1 | Current nibble is the final one of its packet |
| pkt_chain | input | 1 | With `pkt_last`: another packet follows in the same ownership |
| pkt_speed | input | 2 | Speed code of the current packet |
| phy_ctl | input | 2 | Control code driven by the PHY (00 idle, 11 transmit/grant) |
| pkt_ready | output | 1 | Nibble consumed this cycle |
| link_req | output | 1 | Bus request to the PHY |
| link_ctl | output | 2 | Link control code (00 idle, 01 hold, 10 transmit) |
| link_d | output | 4 | Link data nibble |
| link_oe | output | 1 | Enable for the link control and data pads |
| speed_err | output | 1 | Chained packet changed speed |

## Verification
A wrong sequencer state shows up at the ports on the very next clock. The control code and the enable are registered straight from the next state. A missed or spurious grant therefore appears as a request that stays up or drops too early, and the enable switches in the same cycle. A lost last or chain flag turns up one cycle after the final nibble, as idle in place of hold or the reverse. A stale speed register shows up only on the first nibble of a chained packet.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;
  localparam int CTL_W = 2;

  localparam logic [CTL_W-1:0] LCTL_IDLE = 2'b00;
  localparam logic [CTL_W-1:0] LCTL_HOLD = 2'b01;
  localparam logic [CTL_W-1:0] LCTL_XMIT = 2'b10;
  localparam logic [CTL_W-1:0] PCTL_IDLE = 2'b00;
  localparam logic [CTL_W-1:0] PCTL_GRNT = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_HOLD  = 3'd2,
    ST_SEND  = 3'd3,
    ST_CHAIN = 3'd4,
    ST_CLOSE = 3'd5
  } seq_st_t;
endpackage

// File: rtl/lnk_grant_det.sv
module lnk_grant_det
  import lnk_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CTL_W-1:0] phy_ctl,
  output logic             grant
);
  logic [CTL_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= PCTL_IDLE;
    else     prev_q <= phy_ctl;
  end

  assign grant = (prev_q == PCTL_GRNT) && (phy_ctl == PCTL_IDLE);
endmodule

// File: rtl/lnk_tx_fsm.sv
module lnk_tx_fsm
  import lnk_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    send_req,
  input  logic    pkt_valid,
  input  logic    pkt_last,
  input  logic    pkt_chain,
  input  logic    grant,
  output logic    take,
  output logic    pkt_start,
  output logic    first_pkt,
  output seq_st_t nxt_st
);
  seq_st_t st_q;
  logic    last_q, chain_q, first_q;

  always_comb begin
    nxt_st = st_q;
    take   = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (send_req) nxt_st = ST_REQ;
      ST_REQ, ST_CHAIN: begin
        if (grant) begin
          if (pkt_valid) begin
            take   = 1'b1;
            nxt_st = ST_SEND;
          end else begin
            nxt_st = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (pkt_valid) begin
          take   = 1'b1;
          nxt_st = ST_SEND;
        end
      end
      ST_SEND: begin
        if (last_q)         nxt_st = chain_q ? ST_CHAIN : ST_CLOSE;
        else if (pkt_valid) take   = 1'b1;
      end
      ST_CLOSE: nxt_st = ST_IDLE;
      default:  nxt_st = ST_IDLE;
    endcase
  end

  assign pkt_start = take && (st_q != ST_SEND);
  assign first_pkt = first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      last_q  <= 1'b0;
      chain_q <= 1'b0;
      first_q <= 1'b0;
    end else begin
      st_q <= nxt_st;
      if (take) begin
        last_q  <= pkt_last;
        chain_q <= pkt_chain;
      end
      if (st_q == ST_IDLE && send_req) first_q <= 1'b1;
      else if (pkt_start)              first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lnk_speed_guard.sv
module lnk_speed_guard #(
  parameter int SPD_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_start,
  input  logic             first_pkt,
  input  logic [SPD_W-1:0] speed_in,
  output logic             mismatch
);
  logic [SPD_W-1:0] own_spd_q;

  always_ff @(posedge clk) begin
    if (rst)                         own_spd_q <= '0;
    else if (pkt_start && first_pkt) own_spd_q <= speed_in;
  end

  assign mismatch = pkt_start && !first_pkt && (speed_in != own_spd_q);
endmodule

// File: rtl/lnk_tx_drive.sv
module lnk_tx_drive
  import lnk_tx_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_st_t          nxt_st,
  input  logic             take,
  input  logic [NIB_W-1:0] pkt_data,
  input  logic             mismatch,
  output logic             link_req,
  output logic [CTL_W-1:0] link_ctl,
  output logic [NIB_W-1:0] link_d,
  output logic             link_oe,
  output logic             speed_err
);
  logic [CTL_W-1:0] ctl_n;
  logic             oe_n;

  always_comb begin
    ctl_n = LCTL_IDLE;
    oe_n  = 1'b0;
    unique case (nxt_st)
      ST_HOLD, ST_CHAIN: begin ctl_n = LCTL_HOLD; oe_n = 1'b1; end
      ST_SEND:           begin ctl_n = LCTL_XMIT; oe_n = 1'b1; end
      ST_CLOSE:          begin ctl_n = LCTL_IDLE; oe_n = 1'b1; end
      default:           begin ctl_n = LCTL_IDLE; oe_n = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_req  <= 1'b0;
      link_ctl  <= LCTL_IDLE;
      link_d    <= '0;
      link_oe   <= 1'b0;
      speed_err <= 1'b0;
    end else begin
      link_req  <= (nxt_st == ST_REQ);
      link_ctl  <= ctl_n;
      link_d    <= take ? pkt_data : '0;
      link_oe   <= oe_n;
      speed_err <= mismatch;
    end
  end
endmodule

// File: rtl/lnk_tx_seq.sv
module lnk_tx_seq
  import lnk_tx_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int SPD_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             send_req,
  input  logic [NIB_W-1:0] pkt_data,
  input  logic             pkt_valid,
  input  logic             pkt_last,
  input  logic             pkt_chain,
  input  logic [SPD_W-1:0] pkt_speed,
  input  logic [1:0]       phy_ctl,
  output logic             pkt_ready,
  output logic             link_req,
  output logic [1:0]       link_ctl,
  output logic [NIB_W-1:0] link_d,
  output logic             link_oe,
  output logic             speed_err
);
  logic    grant, take, pkt_start, first_pkt, mismatch;
  seq_st_t nxt_st;

  lnk_grant_det u_gdet (
    .clk(clk), .rst(rst), .phy_ctl(phy_ctl), .grant(grant)
  );

  lnk_tx_fsm u_fsm (
    .clk(clk), .rst(rst), .send_req(send_req), .pkt_valid(pkt_valid),
    .pkt_last(pkt_last), .pkt_chain(pkt_chain), .grant(grant),
    .take(take), .pkt_start(pkt_start), .first_pkt(first_pkt), .nxt_st(nxt_st)
  );

  lnk_speed_guard #(.SPD_W(SPD_W)) u_spd (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .first_pkt(first_pkt),
    .speed_in(pkt_speed), .mismatch(mismatch)
  );

  lnk_tx_drive #(.NIB_W(NIB_W)) u_drv (
    .clk(clk), .rst(rst), .nxt_st(nxt_st), .take(take), .pkt_data(pkt_data),
    .mismatch(mismatch), .link_req(link_req), .link_ctl(link_ctl),
    .link_d(link_d), .link_oe(link_oe), .speed_err(speed_err)
  );

  assign pkt_ready = take;
endmodule

// File: rtl/lnk_tx_seq_chk.sv
module lnk_tx_seq_chk #(
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic             link_req,
  input logic [1:0]       link_ctl,
  input logic [NIB_W-1:0] link_d,
  input logic             link_oe,
  input logic             speed_err
);
  // R8
  undriven_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !link_oe |-> (link_ctl == 2'b00 && link_d == '0));
  // R2
  req_own_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(link_req && link_oe));
  // R5
  single_close_chk: assert property (@(posedge clk) disable iff (rst)
    (link_oe && link_ctl == 2'b00) |=> !link_oe);
  // R3
  hold_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (link_ctl == 2'b01) |-> (link_d == '0));
  // R7
  speed_flag_xmit_chk: assert property (@(posedge clk) disable iff (rst)
    speed_err |-> (link_ctl == 2'b10 && link_oe));
  // R4
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_ready |-> pkt_valid);
  // R8
  oe_start_code_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(link_oe) |-> (link_ctl == 2'b01 || link_ctl == 2'b10));
endmodule

bind lnk_tx_seq lnk_tx_seq_chk #(.NIB_W(NIB_W)) chk_i (
  .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .link_req(link_req), .link_ctl(link_ctl), .link_d(link_d),
  .link_oe(link_oe), .speed_err(speed_err)
);

// File: tb/lnk_tx_seq_tb_top.sv
module lnk_tx_seq_tb_top;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       send_req, pkt_valid, pkt_last, pkt_chain;
  logic [3:0] pkt_data;
  logic [1:0] pkt_speed, phy_ctl;
  logic       pkt_ready, link_req, link_oe, speed_err;
  logic [1:0] link_ctl;
  logic [3:0] link_d;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PER/2) clk = ~clk;

  lnk_tx_seq dut_i (
    .clk(clk), .rst(rst), .send_req(send_req), .pkt_data(pkt_data),
    .pkt_valid(pkt_valid), .pkt_last(pkt_last), .pkt_chain(pkt_chain),
    .pkt_speed(pkt_speed), .phy_ctl(phy_ctl), .pkt_ready(pkt_ready),
    .link_req(link_req), .link_ctl(link_ctl), .link_d(link_d),
    .link_oe(link_oe), .speed_err(speed_err)
  );

  function automatic logic [3:0] nib(int pid, int i);
    return 4'((pid * 5 + i * 3 + 1) & 15);
  endfunction

  // One clock: drive at the negedge, check ready before the edge and
  // the registered outputs 1 time unit after it.
  task automatic step(input logic sr, input logic [1:0] phy, input logic v,
                      input logic [3:0] d, input logic l, input logic ch,
                      input logic [1:0] sp, input logic e_rdy,
                      input logic e_req, input logic e_oe,
                      input logic [1:0] e_ctl, input logic [3:0] e_d,
                      input logic e_err, input string tag);
    logic [9:0] got, exp;
    @(negedge clk);
    send_req = sr; phy_ctl = phy; pkt_valid = v; pkt_data = d;
    pkt_last = l; pkt_chain = ch; pkt_speed = sp;
    #1;
    n_cmp++;
    if (pkt_ready !== e_rdy) begin
      n_bad++;
      $display("FAIL %s ready: got %b exp %b", tag, pkt_ready, e_rdy);
    end
    @(posedge clk);
    #1;
    got = {link_req, link_oe, link_ctl, link_d, speed_err, 1'b0};
    exp = {e_req, e_oe, e_ctl, e_d, e_err, 1'b0};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s req/oe/ctl/d/err: got %b exp %b", tag, got, exp);
    end
  endtask

  // Grant (or hold) then stream one packet.
  task automatic take_pkt(int pid, int len, int h, bit ch, logic [1:0] sp,
                          bit e_err);
    if (h == 0) begin
      step(0, 2'b00, 1, nib(pid,0), len == 1, ch, sp, 1, 0, 1, 2'b10,
           nib(pid,0), e_err, "R2 R4 grant+first");
    end else begin
      step(0, 2'b00, 0, 4'h0, 0, 0, sp, 0, 0, 1, 2'b01, 4'h0, 0, "R2 R3 grant+hold");
      for (int k = 1; k < h; k++)
        step(0, 2'b00, 0, 4'h0, 0, 0, sp, 0, 0, 1, 2'b01, 4'h0, 0, "R3 hold");
      step(0, 2'b00, 1, nib(pid,0), len == 1, ch, sp, 1, 0, 1, 2'b10,
           nib(pid,0), e_err, "R4 first after hold");
    end
    for (int i = 1; i < len; i++)
      step(0, 2'b00, 1, nib(pid,i), i == len-1, ch, sp, 1, 0, 1, 2'b10,
           nib(pid,i), 0, "R4 stream");
  endtask

  task automatic close_own();
    step(0, 2'b00, 0, 4'h0, 0, 0, 2'b00, 0, 0, 1, 2'b00, 4'h0, 0, "R5 idle");
    step(0, 2'b00, 0, 4'h0, 0, 0, 2'b00, 0, 0, 0, 2'b00, 4'h0, 0, "R5 R8 release");
  endtask

  task automatic run_own(int pid, int len1, int h1, int g, bit ch,
                         logic [1:0] sp1, logic [1:0] sp2);
    step(1, 2'b00, 0, 4'h0, 0, 0, sp1, 0, 1, 0, 2'b00, 4'h0, 0, "R1 request");
    for (int k = 0; k < g; k++)
      step(0, 2'b11, 0, 4'h0, 0, 0, sp1, 0, 1, 0, 2'b00, 4'h0, 0, "R1 R2 wait grant");
    take_pkt(pid, len1, h1, ch, sp1, 0);
    if (ch) begin
      step(0, 2'b00, 0, 4'h0, 0, 0, sp1, 0, 0, 1, 2'b01, 4'h0, 0, "R6 hold not idle");
      for (int k = 0; k < g; k++)
        step(0, 2'b11, 0, 4'h0, 0, 0, sp1, 0, 0, 1, 2'b01, 4'h0, 0, "R6 chain wait");
      take_pkt(pid + 1, 2, h1 % 2, 0, sp2, sp2 != sp1);
    end
    close_own();
  endtask

  initial begin
    rst = 1'b1; send_req = 0; pkt_valid = 0; pkt_last = 0; pkt_chain = 0;
    pkt_data = 0; pkt_speed = 0; phy_ctl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_cmp++;
    if ({link_req, link_oe, link_ctl, link_d, speed_err, pkt_ready} !== 10'b0) begin
      n_bad++;
      $display("FAIL R8 reset outputs: got %b exp 0",
               {link_req, link_oe, link_ctl, link_d, speed_err, pkt_ready});
    end
    // R2: grant pattern with no request pending is ignored
    step(0, 2'b11, 0, 4'h0, 0, 0, 2'b00, 0, 0, 0, 2'b00, 4'h0, 0, "R2 idle 11");
    step(0, 2'b00, 0, 4'h0, 0, 0, 2'b00, 0, 0, 0, 2'b00, 4'h0, 0, "R2 idle grant ignored");
    // sweep: length, hold cycles, grant width, chaining, speed match
    for (int len1 = 1; len1 <= 4; len1++)
      for (int h1 = 0; h1 <= 2; h1++)
        for (int g = 1; g <= 2; g++)
          for (int ch = 0; ch <= 1; ch++) begin
            logic [1:0] s1, s2;
            s1 = 2'((len1 + h1) % 3);
            s2 = (len1 % 2 == 1) ? s1 : s1 ^ 2'b01;
            run_own(len1 * 10 + h1, len1, h1, g, ch[0], s1, s2); // R7 via s2
          end
    // R9: valid gap in mid-packet
    step(1, 2'b00, 0, 4'h0, 0, 0, 2'b10, 0, 1, 0, 2'b00, 4'h0, 0, "R1 request");
    step(0, 2'b11, 0, 4'h0, 0, 0, 2'b10, 0, 1, 0, 2'b00, 4'h0, 0, "R2 wait");
    step(0, 2'b00, 1, 4'hA, 0, 0, 2'b10, 1, 0, 1, 2'b10, 4'hA, 0, "R4 first");
    step(0, 2'b00, 0, 4'h0, 0, 0, 2'b10, 0, 0, 1, 2'b10, 4'h0, 0, "R9 gap");
    step(0, 2'b11, 0, 4'h0, 0, 0, 2'b10, 0, 0, 1, 2'b10, 4'h0, 0, "R9 gap phy ignored");
    step(0, 2'b00, 1, 4'h5, 1, 0, 2'b10, 1, 0, 1, 2'b10, 4'h5, 0, "R9 resume last");
    close_own();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule